// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block paces a multiplexed external memory bus. It runs from the oscillator clock. It divides each machine cycle of twelve oscillator periods into six states, and each state has two phases. From this timebase it produces two strobes:

- an active-high address-latch strobe, which tells an external latch when the low address byte on the shared bus is valid;
- an active-low program-store strobe, which reads external code memory.

It also drives the high address byte on the upper port.

A strap input selects where code is fetched from. With the strap high, code comes from internal memory while the program counter stays at or below a boundary (1FFFh by default). Above that boundary, and always with the strap low, code is fetched externally. The surrounding core presents the program counter, a data-access request, a pointer-width flag and the upper address byte of a wide pointer, together with the port-2 register value. The block samples all of these once per machine cycle, on the last phase of state 5. Each cycle is therefore either a code-fetch cycle or a data-access cycle. Its kind stays fixed for all twelve periods.

During a data-access cycle the second latch pulse is dropped and no program-store pulse is issued. The upper port then carries either the pointer's high byte or the port-2 register, depending on the access width.

Top module: `ext_bus_sequencer`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `psen_n` is 1, `addr_hi` is all ones, `mc_state` is 5 and `mc_phase` is 1.
- R2: Every clock edge after reset advances the phase. The state advances when the phase returns from 1 to 0. The state counts 0 to 5 and wraps to 0, so that one machine cycle lasts exactly 12 clocks.
- R3: In a code-fetch cycle, `ale` is 1 for both phases of state 0 and both phases of state 3, and 0 otherwise. The latch strobe therefore runs at one sixth of the clock rate.
- R4: In a data-access cycle (`dacc_req` = 1 when sampled), the latch pulse of state 0 still appears and the latch pulse of state 3 is skipped.
- R5: In an external code-fetch cycle, `psen_n` is 0 in exactly four slots and 1 otherwise. The slots are state 1 phase 1, state 2 phase 0, state 4 phase 1 and state 5 phase 0. These are two pulses per machine cycle, and neither coincides with `ale` = 1.
- R6: In a data-access cycle, `psen_n` stays 1 for the whole machine cycle, so both program-store pulses are skipped.
- R7: In an internal code-fetch cycle, `psen_n` stays 1 for the whole machine cycle.
- R8: A fetch is external when `code_int_en` = 0 for any `pc`, or when `code_int_en` = 1 and `pc` > 16'h1FFF. With `code_int_en` = 1, `pc` = 16'h1FFF is internal and `pc` = 16'h2000 is external.
- R9: In a code-fetch cycle, `addr_hi` equals `pc[15:8]` when the fetch is external, and `p2_latch` when it is internal.
- R10: In a data-access cycle, `addr_hi` equals `dacc_hi` when `dacc_wide` = 1 (16-bit pointer), and `p2_latch` when `dacc_wide` = 0 (8-bit register-indirect).
- R11: Inputs are sampled only on the clock edge that leaves state 5 phase 1. Input changes during the rest of the machine cycle have no effect on `ale`, `psen_n` or `addr_hi` until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_int_en | input | 1 | Strap: 1 allows internal code fetches below the boundary |
| pc | input | 16 | Program counter for the next fetch |
| dacc_req | input | 1 | Next machine cycle is an external data access |
| dacc_wide | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit register-indirect access |
| dacc_hi | input | 8 | High byte of the 16-bit data pointer |
| p2_latch | input | 8 | Port-2 register value |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| addr_hi | output | 8 | Byte driven on the upper port |
| mc_state | output | 3 | Current state within the machine cycle (0 to 5) |
| mc_phase | output | 1 | Current phase within the state (0 or 1) |

## Verification
A slip in the state counter shows within one machine cycle, because `ale` then leaves states 0 and 3 and `psen_n` moves out of its four slots. A wrong captured cycle kind or wrong code-source decision shows on `addr_hi` and on the strobes from the first clock of the affected cycle. Such an error is caught at the boundary addresses 1FFFh and 2000h, and on cycles whose inputs change part way through. Context updated outside the cycle boundary shows in the same cycle as the stray input change.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int unsigned N_STATES = 6;
    localparam int unsigned N_PHASES = 2;
    localparam int unsigned ST_W     = $clog2(N_STATES);

    typedef logic [ST_W-1:0] st_t;

    typedef struct packed {
        st_t  st;
        logic ph;
    } tick_t;

    // States that carry the two latch pulses of a machine cycle
    localparam st_t ALE_ST_A = st_t'(0);
    localparam st_t ALE_ST_B = st_t'(N_STATES / 2);
    localparam st_t ST_LAST  = st_t'(N_STATES - 1);

    // Program-store slots sit between the latch pulses, one clock clear of them
    function automatic logic psen_slot(tick_t t);
        return (t.st == st_t'(1) &&  t.ph) ||
               (t.st == st_t'(2) && !t.ph) ||
               (t.st == st_t'(4) &&  t.ph) ||
               (t.st == st_t'(5) && !t.ph);
    endfunction

    function automatic logic is_last_tick(tick_t t);
        return (t.st == ST_LAST) && t.ph;
    endfunction

    function automatic tick_t advance_tick(tick_t t);
        tick_t n;
        n = t;
        if (t.ph) begin
            n.ph = 1'b0;
            n.st = (t.st == ST_LAST) ? st_t'(0) : t.st + st_t'(1);
        end else begin
            n.ph = 1'b1;
        end
        return n;
    endfunction
endpackage

// File: rtl/bss_timebase.sv
module bss_timebase
    import bss_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output tick_t tick_q,
    output tick_t tick_d,
    output logic  wrap_o
);
    always_comb begin
        tick_d = advance_tick(tick_q);
        wrap_o = is_last_tick(tick_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q.st <= ST_LAST;
            tick_q.ph <= 1'b1;
        end else begin
            tick_q <= tick_d;
        end
    end

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q.st == ST_LAST && tick_q.ph) |=> (tick_q.st == st_t'(0) && !tick_q.ph)); // R2
    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tick_q.ph != $past(tick_q.ph))); // R2
    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q.st <= ST_LAST); // R2
endmodule

// File: rtl/bss_cycle_ctx.sv
module bss_cycle_ctx #(
    parameter int unsigned          ADDR_W        = 16,
    parameter logic [ADDR_W-1:0]    INT_CODE_LAST = 16'h1FFF,
    localparam int unsigned         HI_W          = ADDR_W / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrap_i,
    input  logic            code_int_en,
    input  logic [ADDR_W-1:0] pc,
    input  logic            dacc_req,
    input  logic            dacc_wide,
    input  logic [HI_W-1:0] dacc_hi,
    input  logic [HI_W-1:0] p2_latch,
    output logic            ext_d,
    output logic            data_d,
    output logic            ext_q,
    output logic            data_q,
    output logic [HI_W-1:0] hi_q
);
    typedef struct packed {
        logic            ext;
        logic            data;
        logic [HI_W-1:0] hi;
    } ctx_t;

    ctx_t c_d, c_q;
    logic fetch_ext;

    always_comb begin
        fetch_ext = !code_int_en || (pc > INT_CODE_LAST);
        c_d = c_q;
        if (wrap_i) begin
            c_d.ext  = fetch_ext;
            c_d.data = dacc_req;
            if (dacc_req)
                c_d.hi = dacc_wide ? dacc_hi : p2_latch;
            else
                c_d.hi = fetch_ext ? pc[ADDR_W-1 -: HI_W] : p2_latch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.ext  <= 1'b0;
            c_q.data <= 1'b0;
            c_q.hi   <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign ext_d  = c_d.ext;
    assign data_d = c_d.data;
    assign ext_q  = c_q.ext;
    assign data_q = c_q.data;
    assign hi_q   = c_q.hi;

    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(c_q)); // R11
    AST_HI_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && dacc_req && dacc_wide) |=> (hi_q == $past(dacc_hi))); // R10
    AST_HI_EXT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !dacc_req && !code_int_en) |=> (hi_q == $past(pc[ADDR_W-1 -: HI_W]))); // R9
endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
    import bss_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  tick_t tick_d,
    input  tick_t tick_q,
    input  logic  ext_d,
    input  logic  data_d,
    input  logic  ext_q,
    input  logic  data_q,
    output logic  ale_q,
    output logic  psen_n_q
);
    typedef struct packed {
        logic ale;
        logic psen_n;
    } strb_t;

    strb_t s_d, s_q;

    // Decode from the next tick and next context so outputs leave a flop
    always_comb begin
        s_d.ale    = (tick_d.st == ALE_ST_A) || ((tick_d.st == ALE_ST_B) && !data_d);
        s_d.psen_n = !(ext_d && !data_d && psen_slot(tick_d));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ale    <= 1'b0;
            s_q.psen_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ale_q    = s_q.ale;
    assign psen_n_q = s_q.psen_n;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_q && !psen_n_q)); // R5
    AST_ALE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale_q) |-> (!tick_q.ph && (tick_q.st == ALE_ST_A || tick_q.st == ALE_ST_B))); // R3
    AST_DATA_ALE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q && tick_q.st == ALE_ST_B) |-> !ale_q); // R4
    AST_DATA_NO_PSEN: assert property (@(posedge clk) disable iff (!rst_n)
        data_q |-> psen_n_q); // R6
    AST_INT_NO_PSEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_q |-> psen_n_q); // R7
endmodule

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer #(
    parameter int unsigned       ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] INT_CODE_LAST = 16'h1FFF,
    localparam int unsigned      HI_W          = ADDR_W / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     code_int_en,
    input  logic [ADDR_W-1:0]        pc,
    input  logic                     dacc_req,
    input  logic                     dacc_wide,
    input  logic [HI_W-1:0]          dacc_hi,
    input  logic [HI_W-1:0]          p2_latch,
    output logic                     ale,
    output logic                     psen_n,
    output logic [HI_W-1:0]          addr_hi,
    output logic [bss_pkg::ST_W-1:0] mc_state,
    output logic                     mc_phase
);
    import bss_pkg::*;

    tick_t tick_q, tick_d;
    logic  wrap;
    logic  ext_d, data_d, ext_q, data_q;

    bss_timebase u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_q (tick_q),
        .tick_d (tick_d),
        .wrap_o (wrap)
    );

    bss_cycle_ctx #(
        .ADDR_W        (ADDR_W),
        .INT_CODE_LAST (INT_CODE_LAST)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_i      (wrap),
        .code_int_en (code_int_en),
        .pc          (pc),
        .dacc_req    (dacc_req),
        .dacc_wide   (dacc_wide),
        .dacc_hi     (dacc_hi),
        .p2_latch    (p2_latch),
        .ext_d       (ext_d),
        .data_d      (data_d),
        .ext_q       (ext_q),
        .data_q      (data_q),
        .hi_q        (addr_hi)
    );

    bss_strobe_gen u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_d   (tick_d),
        .tick_q   (tick_q),
        .ext_d    (ext_d),
        .data_d   (data_d),
        .ext_q    (ext_q),
        .data_q   (data_q),
        .ale_q    (ale),
        .psen_n_q (psen_n)
    );

    assign mc_state = tick_q.st;
    assign mc_phase = tick_q.ph;

    AST_ALE_ONCE_PER_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && mc_phase) |=> (!ale || mc_state == ALE_ST_A)); // R3
endmodule

// File: tb/ext_bus_sequencer_bench.sv
module ext_bus_sequencer_bench;
    localparam int WATCHDOG_CYC = 200000;

    typedef struct packed {
        logic       ale;
        logic       psen_n;
        logic [7:0] hi;
        logic [2:0] st;
        logic       ph;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_int_en = 1'b1;
    logic [15:0] pc = '0;
    logic        dacc_req = 1'b0;
    logic        dacc_wide = 1'b0;
    logic [7:0]  dacc_hi = '0;
    logic [7:0]  p2_latch = '0;
    logic        ale, psen_n, mc_phase;
    logic [7:0]  addr_hi;
    logic [2:0]  mc_state;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    exp_t  q_exp[$];
    string q_tag_ale[$];
    string q_tag_psen[$];
    string q_tag_hi[$];

    always #5 clk = ~clk;

    ext_bus_sequencer u_ext_bus_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_int_en (code_int_en),
        .pc          (pc),
        .dacc_req    (dacc_req),
        .dacc_wide   (dacc_wide),
        .dacc_hi     (dacc_hi),
        .p2_latch    (p2_latch),
        .ale         (ale),
        .psen_n      (psen_n),
        .addr_hi     (addr_hi),
        .mc_state    (mc_state),
        .mc_phase    (mc_phase)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: called while the design sits in state 5 phase 1
    task automatic run_cycle(logic ea, logic [15:0] pcv, logic req, logic wide,
                             logic [7:0] dhi, logic [7:0] p2v, bit scramble, string tag_ovr);
        logic       ext;
        logic [7:0] hi;
        code_int_en = ea; pc = pcv; dacc_req = req; dacc_wide = wide;
        dacc_hi = dhi; p2_latch = p2v;
        ext = !ea || (pcv > 16'h1FFF);
        hi  = req ? (wide ? dhi : p2v) : (ext ? pcv[15:8] : p2v);
        for (int k = 0; k < 12; k++) begin
            exp_t e;
            int s;
            logic slot;
            s = k / 2;
            e.st = 3'(s);
            e.ph = 1'(k % 2);
            e.ale = (s == 0) || (s == 3 && !req);
            slot = (s == 1 && e.ph) || (s == 2 && !e.ph) || (s == 4 && e.ph) || (s == 5 && !e.ph);
            e.psen_n = !(ext && !req && slot);
            e.hi = hi;
            q_exp.push_back(e);
            if (tag_ovr != "") begin
                q_tag_ale.push_back(tag_ovr);
                q_tag_psen.push_back(tag_ovr);
                q_tag_hi.push_back(tag_ovr);
            end else begin
                q_tag_ale.push_back(req ? "R4" : "R3");
                q_tag_psen.push_back(req ? "R6" : (ext ? "R5" : "R7"));
                q_tag_hi.push_back(req ? "R10" : "R9");
            end
        end
        repeat (5) @(negedge clk);
        if (scramble) begin
            code_int_en = ~ea; pc = ~pcv; dacc_req = ~req; dacc_wide = ~wide;
            dacc_hi = ~dhi; p2_latch = ~p2v;
        end
        repeat (7) @(negedge clk);
    endtask

    // Monitor: compares outputs against the scoreboard after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                exp_t  e;
                string ta, tp, th;
                e  = q_exp.pop_front();
                ta = q_tag_ale.pop_front();
                tp = q_tag_psen.pop_front();
                th = q_tag_hi.pop_front();
                check("R2", 8'(mc_state), 8'(e.st), "state");
                check("R2", 8'(mc_phase), 8'(e.ph), "phase");
                check(ta, 8'(ale), 8'(e.ale), "ale");
                check(tp, 8'(psen_n), 8'(e.psen_n), "psen_n");
                check(th, addr_hi, e.hi, "addr_hi");
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 8'(ale), 8'h0, "reset ale");
        check("R1", 8'(psen_n), 8'h1, "reset psen_n");
        check("R1", addr_hi, 8'hFF, "reset addr_hi");
        check("R1", 8'(mc_state), 8'h5, "reset state");
        check("R1", 8'(mc_phase), 8'h1, "reset phase");
        rst_n = 1'b1;
        run_cycle(1'b1, 16'h0123, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b0, "");   // internal fetch
        run_cycle(1'b1, 16'h1FFF, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b0, "R8"); // last internal address
        run_cycle(1'b1, 16'h2000, 1'b0, 1'b0, 8'h00, 8'h11, 1'b0, "R8"); // first external address
        run_cycle(1'b0, 16'h0040, 1'b0, 1'b0, 8'h00, 8'h22, 1'b0, "R8"); // strap low forces external
        run_cycle(1'b0, 16'h9ABC, 1'b0, 1'b0, 8'h00, 8'h33, 1'b0, "");   // external fetch
        run_cycle(1'b0, 16'h4000, 1'b1, 1'b1, 8'hC3, 8'h44, 1'b0, "");   // wide data access
        run_cycle(1'b0, 16'h4001, 1'b1, 1'b0, 8'hC3, 8'h77, 1'b0, "");   // narrow data access
        run_cycle(1'b1, 16'h0100, 1'b1, 1'b1, 8'h8E, 8'h10, 1'b0, "");   // data while running internal
        run_cycle(1'b1, 16'hF000, 1'b0, 1'b0, 8'h00, 8'h55, 1'b0, "");   // external again after data
        run_cycle(1'b0, 16'h8421, 1'b0, 1'b0, 8'h3C, 8'h66, 1'b1, "R11"); // mid-cycle input churn
        run_cycle(1'b1, 16'h0200, 1'b1, 1'b0, 8'hE1, 8'h99, 1'b1, "R11");
        run_cycle(1'b1, 16'h0300, 1'b0, 1'b0, 8'h00, 8'hBE, 1'b0, "");
        @(posedge clk);
        #5;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule